// File: doc/BRIEF.md
# Chase Soft-Decision Decoder for the Extended Hamming (32,26) Code

This block decodes one row or column of a product code built on the extended Hamming (32,26) component code. Each word arrives as 32 signed soft samples. The decoder takes the sign of each sample as the hard decision and the magnitude as its reliability. It then marks the three least reliable positions.

Eight test words are formed by flipping every subset of those three positions. Each test word is run through a syndrome correction and has its overall parity bit rebuilt. Each candidate is scored by the reliability it has to overturn, which is the squared Euclidean distance up to a constant. The cheapest candidate is returned with its score.

One test pattern is evaluated per clock, and a running minimum is kept. The surrounding turbo loop works out extrinsic values and controls the iterations, and it talks to the block over a valid/ready handshake on both sides.

Top module: `chase_hamming_decoder`

## Requirements
- R1: Sample i sits at `in_soft[6*i +: 6]` as a 6-bit two's-complement value. Its hard decision is 1 exactly when the sample is negative.
- R2: The reliability of a sample is its magnitude, so -32 counts as 32 and 0 counts as 0.
- R3: The three least reliable positions are the three smallest magnitudes. On equal magnitude, the lower bit index counts as less reliable.
- R4: Test pattern k (k = 0..7) flips the hard word at the b-th least reliable position whenever bit b of k is set. Pattern 0 is the hard word itself.
- R5: The syndrome of a word is the XOR of the indices i in 1..31 whose bit is 1. A nonzero syndrome flips the bit at that index, and a zero syndrome flips nothing.
- R6: After correction, bit 0 is rewritten as the XOR of bits 1..31. Every output word therefore has zero syndrome and even weight.
- R7: A candidate's metric is the sum of magnitudes over the positions where it differs from the hard word. The output is the candidate with the smallest metric, and a tie goes to the lower pattern number.
- R8: `in_ready` is high only while idle, and `in_valid` is ignored at all other times. After an accepting edge, `out_valid` rises on the 9th rising edge counting the accepting edge as the first. `in_ready` and `out_valid` are never high together.
- R9: While `out_valid` is high and `out_ready` is low, `out_code` and `out_metric` hold. The cycle after an edge with `out_ready` high, the block is idle again.
- R10: After reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A soft word is offered |
| in_ready | output | 1 | Decoder idle, word will be taken |
| in_soft | input | 192 | 32 soft samples of 6 bits, sample i at bits 6*i+5..6*i |
| out_valid | output | 1 | Decoded word available |
| out_ready | input | 1 | Consumer takes the decoded word |
| out_code | output | 32 | Winning candidate codeword, bit 0 is the overall parity |
| out_metric | output | 11 | Metric of the winning candidate |

## Verification
Strong uniform words of either sign check that valid codewords pass unchanged with zero metric. A single weak wrong sign separates plain syndrome correction from the test-pattern search. A pair of weak wrong signs is a case that only the flipped patterns can repair, so it exposes a missing or misordered pattern set. Words with a -32 sample, words full of equal magnitudes, and randomly drawn words probe the magnitude rule, the tie-breaking among unreliable positions and the metric minimum. Back-pressure runs and stray input offers during a search confirm that the output holds and that busy-time offers are ignored.

// File: rtl/chase_pkg.sv
package chase_pkg;
  typedef enum logic [1:0] {
    CH_IDLE   = 2'd0,
    CH_SEARCH = 2'd1,
    CH_HOLD   = 2'd2
  } chase_state_e;
endpackage

// File: rtl/chase_lrp_select.sv
module chase_lrp_select #(
  parameter int N = 32,
  parameter int W = 6,
  parameter int L = 3,
  parameter int M = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N*W-1:0] soft_mag,
  output logic [L*M-1:0] lrp_idx
);
  logic [M-1:0] rank [N];
  logic [W-1:0] sel_mag [L];

  // rank = number of positions that are strictly less reliable
  always_comb begin
    for (int i = 0; i < N; i++) begin
      rank[i] = '0;
      for (int j = 0; j < N; j++) begin
        if (j != i) begin
          if ((soft_mag[j*W +: W] < soft_mag[i*W +: W]) ||
              ((soft_mag[j*W +: W] == soft_mag[i*W +: W]) && (j < i)))
            rank[i] = rank[i] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    lrp_idx = '0;
    for (int b = 0; b < L; b++) begin
      for (int i = 0; i < N; i++) begin
        if (rank[i] == M'(b)) lrp_idx[b*M +: M] = M'(i);
      end
    end
  end

  always_comb begin
    for (int b = 0; b < L; b++) sel_mag[b] = soft_mag[lrp_idx[b*M +: M]*W +: W];
  end

  generate
    for (genvar b = 1; b < L; b++) begin : g_order
      // R3: selected positions are distinct and ordered by reliability
      p_lrp_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lrp_idx[(b-1)*M +: M] != lrp_idx[b*M +: M]) && (sel_mag[b-1] <= sel_mag[b]));
    end
  endgenerate
endmodule

// File: rtl/chase_candidate.sv
module chase_candidate #(
  parameter int N  = 32,
  parameter int W  = 6,
  parameter int L  = 3,
  parameter int M  = 5,
  parameter int MW = 11
) (
  input  logic [N-1:0]   hard,
  input  logic [N*W-1:0] soft_mag,
  input  logic [L*M-1:0] lrp_idx,
  input  logic [L-1:0]   pat,
  output logic [N-1:0]   cand_code,
  output logic [MW-1:0]  cand_metric
);
  logic [N-1:0] test_word;
  logic [M-1:0] syn;
  logic         fix_hit;

  function automatic logic [M-1:0] f_syndrome(input logic [N-1:0] w);
    logic [M-1:0] s;
    s = '0;
    for (int i = 1; i < N; i++) if (w[i]) s = s ^ M'(i);
    return s;
  endfunction

  function automatic logic [MW-1:0] f_metric(input logic [N-1:0] a,
                                             input logic [N-1:0] ref_w,
                                             input logic [N*W-1:0] mags);
    logic [MW-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) if (a[i] != ref_w[i]) acc = acc + MW'(mags[i*W +: W]);
    return acc;
  endfunction

  always_comb begin
    test_word = hard;
    for (int b = 0; b < L; b++) begin
      if (pat[b]) test_word[lrp_idx[b*M +: M]] = ~test_word[lrp_idx[b*M +: M]];
    end
  end

  assign syn     = f_syndrome(test_word);
  assign fix_hit = (syn != '0);

  always_comb begin
    cand_code = test_word;
    if (fix_hit) cand_code[syn] = ~cand_code[syn];
    cand_code[0] = ^cand_code[N-1:1];
  end

  assign cand_metric = f_metric(cand_code, hard, soft_mag);
endmodule

// File: rtl/chase_best_track.sv
module chase_best_track #(
  parameter int N  = 32,
  parameter int MW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [N-1:0]  cand_code,
  input  logic [MW-1:0] cand_metric,
  output logic [N-1:0]  best_code,
  output logic [MW-1:0] best_metric
);
  logic take;

  // strict less-than keeps the earlier pattern on a tie
  assign take = load || (step && (cand_metric < best_metric));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      best_code   <= '0;
      best_metric <= '0;
    end else if (take) begin
      best_code   <= cand_code;
      best_metric <= cand_metric;
    end
  end

  // R7: running minimum never grows during a search
  p_min_monotone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (best_metric <= $past(best_metric)));
  // R7: after a step the kept metric is no worse than the candidate offered
  p_min_vs_cand_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (best_metric <= $past(cand_metric)));
endmodule

// File: rtl/chase_hamming_decoder.sv
module chase_hamming_decoder #(
  parameter int N = 32,
  parameter int W = 6,
  parameter int L = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_valid,
  output logic                                   in_ready,
  input  logic [N*W-1:0]                         in_soft,
  output logic                                   out_valid,
  input  logic                                   out_ready,
  output logic [N-1:0]                           out_code,
  output logic [$clog2(N*(1<<(W-1))+1)-1:0]      out_metric
);
  import chase_pkg::*;

  localparam int M  = $clog2(N);
  localparam int P  = 1 << L;
  localparam int MW = $clog2(N*(1<<(W-1))+1);

  chase_state_e  state;
  logic [L-1:0]  pat_cnt;
  logic [N*W-1:0] soft_q;
  logic [N-1:0]  hard;
  logic [N*W-1:0] soft_mag;
  logic [L*M-1:0] lrp_idx;
  logic [N-1:0]  cand_code;
  logic [MW-1:0] cand_metric;
  logic          accept;
  logic          search_last;
  logic          trk_load;
  logic          trk_step;

  function automatic logic [W-1:0] f_mag(input logic [W-1:0] s);
    return s[W-1] ? (~s + 1'b1) : s;
  endfunction

  function automatic logic [M-1:0] f_syndrome(input logic [N-1:0] w);
    logic [M-1:0] s;
    s = '0;
    for (int i = 1; i < N; i++) if (w[i]) s = s ^ M'(i);
    return s;
  endfunction

  generate
    for (genvar i = 0; i < N; i++) begin : g_split
      assign hard[i]              = soft_q[i*W + W - 1];
      assign soft_mag[i*W +: W]   = f_mag(soft_q[i*W +: W]);
    end
  endgenerate

  assign accept      = in_valid && in_ready;
  assign search_last = (state == CH_SEARCH) && (pat_cnt == L'(P-1));
  assign trk_load    = (state == CH_SEARCH) && (pat_cnt == '0);
  assign trk_step    = (state == CH_SEARCH) && (pat_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= CH_IDLE;
      pat_cnt <= '0;
      soft_q  <= '0;
    end else begin
      case (state)
        CH_IDLE: if (accept) begin
          soft_q  <= in_soft;
          pat_cnt <= '0;
          state   <= CH_SEARCH;
        end
        CH_SEARCH: begin
          pat_cnt <= pat_cnt + 1'b1;
          if (search_last) state <= CH_HOLD;
        end
        CH_HOLD: if (out_ready) state <= CH_IDLE;
        default: state <= CH_IDLE;
      endcase
    end
  end

  chase_lrp_select #(.N(N), .W(W), .L(L), .M(M)) u_lrp (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_mag (soft_mag),
    .lrp_idx  (lrp_idx)
  );

  chase_candidate #(.N(N), .W(W), .L(L), .M(M), .MW(MW)) u_cand (
    .hard        (hard),
    .soft_mag    (soft_mag),
    .lrp_idx     (lrp_idx),
    .pat         (pat_cnt),
    .cand_code   (cand_code),
    .cand_metric (cand_metric)
  );

  chase_best_track #(.N(N), .MW(MW)) u_best (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (trk_load),
    .step        (trk_step),
    .cand_code   (cand_code),
    .cand_metric (cand_metric),
    .best_code   (out_code),
    .best_metric (out_metric)
  );

  assign in_ready  = (state == CH_IDLE);
  assign out_valid = (state == CH_HOLD);

  // R6: every candidate leaving the corrector is a codeword
  p_cand_codeword_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CH_SEARCH) |-> ((f_syndrome(cand_code) == '0) && !(^cand_code)));
  // R6: the delivered word is a codeword
  p_out_codeword_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((f_syndrome(out_code) == '0) && !(^out_code)));
  // R8: input and output sides never both open
  p_side_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  // R8: an accepted word closes the input side
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  // R8: output appears only after a search
  p_out_after_search_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(state == CH_SEARCH));
  // R9: result held under back-pressure
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_metric)));
  // R9: taken result frees the decoder
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready);
endmodule

// File: tb/sim_chase_hamming_decoder.sv
module sim_chase_hamming_decoder;
  localparam int N  = 32;
  localparam int W  = 6;
  localparam int MW = 11;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic           in_ready;
  logic [N*W-1:0] in_soft;
  logic           out_valid;
  logic           out_ready;
  logic [N-1:0]   out_code;
  logic [MW-1:0]  out_metric;

  always #5 clk = ~clk;

  chase_hamming_decoder #(.N(N), .W(W), .L(3)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_soft(in_soft), .out_valid(out_valid), .out_ready(out_ready),
    .out_code(out_code), .out_metric(out_metric)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  int    cycles   = 0;
  bit    check_en = 0;
  string cur_tag  = "R7";

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference
  function automatic void ref_decode(input logic [N*W-1:0] s,
                                     output logic [N-1:0] code, output int metric);
    int mag[N];
    logic [N-1:0] hd;
    int least[3];
    bit used[N];
    for (int i = 0; i < N; i++) begin
      int v;
      v = $signed(s[i*W +: W]);
      hd[i] = (v < 0);
      mag[i] = (v < 0) ? -v : v;
      used[i] = 0;
    end
    for (int b = 0; b < 3; b++) begin
      int pick;
      pick = -1;
      for (int i = 0; i < N; i++)
        if (!used[i] && (pick < 0 || mag[i] < mag[pick])) pick = i;
      least[b] = pick;
      used[pick] = 1;
    end
    metric = 1 << 30;
    code = '0;
    for (int k = 0; k < 8; k++) begin
      logic [N-1:0] t;
      int syn;
      int m;
      bit par;
      t = hd;
      for (int b = 0; b < 3; b++) if (((k >> b) & 1) == 1) t[least[b]] = ~t[least[b]];
      syn = 0;
      for (int i = 1; i < N; i++) if (t[i]) syn = syn ^ i;
      if (syn != 0) t[syn] = ~t[syn];
      par = 0;
      for (int i = 1; i < N; i++) par = par ^ t[i];
      t[0] = par;
      m = 0;
      for (int i = 0; i < N; i++) if (t[i] != hd[i]) m += mag[i];
      if (m < metric) begin
        metric = m;
        code = t;
      end
    end
  endfunction

  // cycle model: 0 idle, 1..8 searching, 9 holding
  int           m_phase;
  logic [N-1:0] m_code;
  int           m_metric;
  logic [N-1:0] t_code;
  int           t_metric;

  always @(posedge clk) begin
    if (!rst_n) m_phase <= 0;
    else begin
      if (m_phase == 0) begin
        if (in_valid) begin
          ref_decode(in_soft, t_code, t_metric);
          m_code   <= t_code;
          m_metric <= t_metric;
          m_phase  <= 1;
        end
      end else if (m_phase < 9) m_phase <= m_phase + 1;
      else if (out_ready) m_phase <= 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && check_en) begin
      chk(in_ready === (m_phase == 0), "R8", "in_ready", longint'(in_ready), longint'(m_phase == 0));
      chk(out_valid === (m_phase == 9), "R8", "out_valid", longint'(out_valid), longint'(m_phase == 9));
      if (m_phase == 9) begin
        chk(out_code === m_code, cur_tag, "out_code", longint'(out_code), longint'(m_code));
        chk(int'(out_metric) == m_metric, cur_tag, "out_metric", longint'(out_metric), longint'(m_metric));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", cycles, 0);
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  function automatic logic [N*W-1:0] fill(input int v);
    logic [N*W-1:0] w;
    for (int i = 0; i < N; i++) w[i*W +: W] = W'(v);
    return w;
  endfunction

  function automatic logic [N*W-1:0] setp(input logic [N*W-1:0] w, input int i, input int v);
    logic [N*W-1:0] r;
    r = w;
    r[i*W +: W] = W'(v);
    return r;
  endfunction

  // offer a word, optionally poke inputs while busy, stall output, hand-check
  task automatic run(input logic [N*W-1:0] s, input string tag, input int stall,
                     input bit poke, input bit use_exp,
                     input logic [N-1:0] e_code, input int e_metric);
    @(negedge clk);
    cur_tag   = tag;
    in_soft   = s;
    in_valid  = 1'b1;
    out_ready = (stall == 0);
    @(negedge clk);
    if (poke) begin
      in_soft = ~s;
      repeat (4) @(negedge clk);
    end
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    if (use_exp) begin
      chk(out_code === e_code, tag, "hand out_code", longint'(out_code), longint'(e_code));
      chk(int'(out_metric) == e_metric, tag, "hand out_metric", longint'(out_metric), longint'(e_metric));
    end
    if (stall > 0) begin
      cur_tag = "R9";
      repeat (stall) @(negedge clk);
      out_ready = 1'b1;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    logic [N*W-1:0] w;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_soft = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1, "R10", "in_ready after reset", longint'(in_ready), 1);
    chk(out_valid === 1'b0, "R10", "out_valid after reset", longint'(out_valid), 0);
    check_en = 1;

    run(fill(31), "R1", 0, 0, 1, '0, 0);
    run(fill(-31), "R6", 0, 0, 1, '1, 0);
    run(setp(fill(20), 5, -3), "R5", 0, 0, 1, '0, 3);
    run(setp(fill(31), 9, -32), "R2", 0, 0, 1, '0, 32);
    w = setp(setp(fill(31), 1, -2), 2, -2);
    run(w, "R4", 0, 0, 1, '0, 4);
    w = setp(setp(setp(fill(10), 3, -10), 20, -10), 21, -10);
    run(w, "R3", 0, 0, 0, '0, 0);
    w = setp(setp(fill(7), 30, -7), 17, -7);
    run(w, "R3", 3, 0, 0, '0, 0);
    run(setp(fill(-12), 4, 12), "R8", 0, 1, 0, '0, 0);
    run(setp(fill(25), 11, -1), "R9", 5, 1, 0, '0, 0);
    for (int n = 0; n < 24; n++) begin
      logic [N*W-1:0] rw;
      for (int i = 0; i < N; i++) rw[i*W +: W] = W'($urandom_range(0, 63));
      run(rw, "R7", (n % 3), (n % 4) == 1, 0, '0, 0);
    end
    for (int n = 0; n < 12; n++) begin
      logic [N*W-1:0] rw;
      rw = fill(($urandom_range(0, 1) == 1) ? 24 : -24);
      for (int e = 0; e < 3; e++) rw = setp(rw, $urandom_range(0, N-1), $urandom_range(0, 8) - 4);
      run(rw, "R7", 0, 0, 0, '0, 0);
    end
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule